// File: doc/BRIEF.md
# Reset Cause Status Register

This block is the read-only status word of a reset controller. It keeps a 3-bit code for the cause of the most recent processor reset, and it shows the live level of the external active-low reset pin after a synchronizer. It also shows whether a software reset command is still running. A sticky flag records any high-to-low edge of the pin since the last read, and that flag drives an interrupt line.

Software reads the word through a single-cycle read port. When the port addresses the status offset, the read returns the current contents combinationally. At the next clock edge it clears the sticky edge flag, and the interrupt drops with it.

The reset causes arrive as one-cycle strobes: crystal failure, watchdog fault, software request and completion. A pin falling edge is also a cause. The block's own asynchronous reset loads the cause code from a power-up qualifier. That qualifier tells whether only the core supply came up or whether the backup domain came up as well.

Top module: `rst_cause_status`

## Requirements
- R1: While `rst_n` is low, the cause code is 1 if `bkup_por` is 0 and 0 if `bkup_por` is 1. The busy bit, the synchronized pin bit and the edge flag are all 0, so a status read returns 0x00000100 or 0x00000000 respectively.
- R2: The cause code sits in bits 10:8. It loads 7 for `xtal_fail`, 2 for `wdt_fault`, 3 for an accepted `sw_req` and 4 for a synchronized pin falling edge. When several of these arrive in one cycle, the priority order is 7, then 2, then 3, then 4.
- R3: A status read never changes the cause code.
- R4: Bit 16 equals `pin_n` delayed by a two-flop synchronizer, so it is valid two rising edges after the pin changes.
- R5: Bit 0 is set by the third rising edge after `pin_n` falls. A rising edge of `pin_n` never sets it.
- R6: A status read returns bit 0 and then clears it at the same clock edge. `irq` equals bit 0 at all times.
- R7: If a falling edge is detected in the same cycle as a status read, bit 0 stays set after that edge.
- R8: Bit 17 is set by `sw_req` when it is 0 and cleared by `sw_done`. An `sw_req` that arrives while bit 17 is 1 has no effect on the cause code or on bit 17.
- R9: Only a read at byte offset 0x04 is a status read. Any other offset returns 0 and leaves bit 0 unchanged. Bits 31:18, 15:11 and 7:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| bkup_por | input | 1 | 1 when the backup domain powered up together with the core |
| pin_n | input | 1 | External active-low reset pin, asynchronous |
| xtal_fail | input | 1 | Crystal oscillator failure strobe |
| wdt_fault | input | 1 | Watchdog fault strobe |
| sw_req | input | 1 | Software reset command strobe |
| sw_done | input | 1 | Software reset completion strobe |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt, high while the edge flag is set |

## Verification
The hardest case is a read that lands in exactly the cycle in which the synchronizer reports a falling edge. It is hard because the edge is detected two flops after the asynchronous pin changes. The stimulus drives the pin low just after a falling clock edge and counts two rising edges. It then issues the read in the following cycle. That read must return the old flag, and the next read must find the flag still set. A second hard case is showing that a software request made while busy is ignored. To do this, the stimulus first moves the cause code away from 3 with a watchdog strobe, so that a wrongly accepted request becomes visible.

// File: rtl/rst_cause_status.sv
module rst_cause_status #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h04,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bkup_por,
  input  logic              pin_n,
  input  logic              xtal_fail,
  input  logic              wdt_fault,
  input  logic              sw_req,
  input  logic              sw_done,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam logic [2:0] CAUSE_GEN  = 3'd0;
  localparam logic [2:0] CAUSE_WAKE = 3'd1;
  localparam logic [2:0] CAUSE_WDT  = 3'd2;
  localparam logic [2:0] CAUSE_SW   = 3'd3;
  localparam logic [2:0] CAUSE_PIN  = 3'd4;
  localparam logic [2:0] CAUSE_XTAL = 3'd7;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_prev_q, flag_q, busy_q;
  logic [2:0] cause_q, cause_nxt;
  logic pin_lvl, fall, sw_take, rd_hit, cause_ld;

  assign pin_lvl = sync_q[SYNC_STAGES-1];
  assign fall    = pin_prev_q & ~pin_lvl;
  assign sw_take = sw_req & ~busy_q;
  assign rd_hit  = rd_en && (rd_addr == STATUS_OFS);
  assign cause_ld = xtal_fail | wdt_fault | sw_take | fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q     <= '0;
      pin_prev_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], pin_n};
      pin_prev_q <= pin_lvl;
    end

  always_comb begin
    cause_nxt = cause_q;
    if (xtal_fail)      cause_nxt = CAUSE_XTAL;
    else if (wdt_fault) cause_nxt = CAUSE_WDT;
    else if (sw_take)   cause_nxt = CAUSE_SW;
    else if (fall)      cause_nxt = CAUSE_PIN;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cause_q <= bkup_por ? CAUSE_GEN : CAUSE_WAKE;
      busy_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (cause_ld) cause_q <= cause_nxt;
      busy_q <= busy_q ? ~sw_done : sw_req;
      if (fall)        flag_q <= 1'b1;
      else if (rd_hit) flag_q <= 1'b0;
    end

  assign rd_data = rd_hit ? {14'b0, busy_q, pin_lvl, 5'b0, cause_q, 7'b0, flag_q} : 32'b0;
  assign irq = flag_q;

  assert_read_keeps_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !cause_ld) |=> $stable(cause_q));
  assert_xtal_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_fail |=> (rd_data[10:8] == CAUSE_XTAL || !rd_hit));
  assert_wdt_over_sw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_fault && !xtal_fail) |=> (cause_q == CAUSE_WDT));
  assert_edge_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> irq);
  assert_read_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !fall) |=> !irq);
  assert_other_ofs_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && !fall) |=> $stable(flag_q));
  assert_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && sw_req) |=> busy_q);
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sw_req && !sw_done && !xtal_fail && !wdt_fault && !fall) |=> (busy_q && $stable(cause_q)));
  always_comb if (rst_n) assert_unused_zero_R9: assert ({rd_data[31:18], rd_data[15:11], rd_data[7:1]} == '0);
endmodule

// File: tb/rst_cause_status_tb_top.sv
module rst_cause_status_tb_top;
  logic clk = 0, rst_n = 0, bkup_por = 0, pin_n = 1;
  logic xtal_fail = 0, wdt_fault = 0, sw_req = 0, sw_done = 0, rd_en = 0;
  logic [7:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic irq;
  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  rst_cause_status dut_i (.clk, .rst_n, .bkup_por, .pin_n, .xtal_fail, .wdt_fault,
    .sw_req, .sw_done, .rd_en, .rd_addr, .rd_data, .irq);

  function automatic logic [31:0] word(logic busy, logic lvl, logic [2:0] c, logic f);
    return {14'b0, busy, lvl, 5'b0, c, 7'b0, f};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk); #1;
    rd_addr = a; rd_en = 1; exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(logic x, logic w, logic s, logic d);
    @(negedge clk); #1;
    xtal_fail = x; wdt_fault = w; sw_req = s; sw_done = d;
    @(negedge clk);
    xtal_fail = 0; wdt_fault = 0; sw_req = 0; sw_done = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  always @(negedge clk) begin
    #3;
    if (rd_en) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(2);
    rd(8'h04, 32'h0000_0100, "R1 core-only reset");
    @(negedge clk); rst_n = 1;
    cyc(3);
    rd(8'h04, word(0, 1, 1, 0), "R4 pin level high");
    rd(8'h04, word(0, 1, 1, 0), "R3 cause kept after read");
    pulse(0, 1, 0, 0);
    rd(8'h04, word(0, 1, 2, 0), "R2 watchdog code");
    pulse(0, 0, 1, 0);
    rd(8'h04, word(1, 1, 3, 0), "R8 busy set, software code");
    pulse(0, 1, 0, 0);
    pulse(0, 0, 1, 0);
    rd(8'h04, word(1, 1, 2, 0), "R8 request while busy ignored");
    pulse(0, 0, 0, 1);
    rd(8'h04, word(0, 1, 2, 0), "R8 busy cleared");
    @(negedge clk); #1; pin_n = 0;
    cyc(4);
    chk("R6 irq with flag", {31'b0, irq}, 32'd1);
    rd(8'h04, word(0, 0, 4, 1), "R5 falling edge flag, R2 pin code");
    chk("R6 irq after read", {31'b0, irq}, 32'd0);
    rd(8'h04, word(0, 0, 4, 0), "R6 flag cleared by read");
    @(negedge clk); #1; pin_n = 1;
    cyc(4);
    rd(8'h04, word(0, 1, 4, 0), "R5 rising edge ignored");
    @(negedge clk); #1; pin_n = 0;
    cyc(4);
    rd(8'h08, 32'h0, "R9 other offset reads zero");
    rd(8'h04, word(0, 0, 4, 1), "R9 other offset kept flag");
    @(negedge clk); #1; pin_n = 1;
    cyc(4);
    @(negedge clk); #1; pin_n = 0;
    cyc(2);
    rd(8'h04, word(0, 0, 4, 0), "R7 read in edge cycle returns old flag");
    rd(8'h04, word(0, 0, 4, 1), "R7 flag survives coincident read");
    pulse(1, 1, 1, 0);
    rd(8'h04, word(1, 0, 7, 0), "R2 crystal wins over all");
    pulse(0, 0, 0, 1);
    pulse(0, 1, 1, 0);
    rd(8'h04, word(1, 0, 2, 0), "R2 watchdog over software");
    pulse(0, 0, 0, 1);
    @(negedge clk); bkup_por = 1; rst_n = 0;
    cyc(2);
    rd(8'h04, 32'h0, "R1 full power-up reset");
    chk("R1 irq in reset", {31'b0, irq}, 32'd0);
    cyc(2);
    finish_run();
  end
endmodule